// File: doc/BRIEF.md
# Per-Channel Label Acceptance Filter

This block decides, for each of several receive channels, whether a finished data word is kept or thrown away, based on the word's label. Every channel has its own one-bit-per-label acceptance table: a 1 at a label's entry lets words with that label through, a 0 drops them. When a channel's serial front end signals end of word, the block looks up the label in that channel's table. One clock later it reports keep or drop. A kept word raises the channel's pending flag.

A host loads the tables over a simple register bus. One access addresses one label entry in all channel tables at once: data bit c carries the entry for channel c. A channel's table only takes writes while its program-enable input is high. While that input is high the channel also stops judging incoming words. Lowering it returns the channel to normal reception. Reads return the current entries at the addressed label, with the same bit layout, on the low byte of a 16-bit read bus. Only the low byte lane carries data, so byte and word accesses behave the same.

Top module: `lbl_accept_matrix`

## Requirements
- R1: After reset every table entry of every channel is 0, and `rx_keep`, `rx_drop`, `rx_pending` and `hst_rdata` are all 0.
- R2: A host write (`hst_sel`=1, `hst_wr`=1) stores `hst_wdata[c]` at entry `hst_addr` of channel c's table for every channel c whose `prog_en[c]` is 1.
- R3: A host write leaves channel c's table unchanged when `prog_en[c]` is 0.
- R4: A host read (`hst_sel`=1, `hst_wr`=0) loads `hst_rdata[c]` with entry `hst_addr` of channel c's table on the next clock edge. `hst_rdata[15:8]` is 0. `hst_rdata` holds its value until the next read.
- R5: Reads ignore `prog_en`. Every channel's entry is returned whatever its program-enable state.
- R6: When `rx_eom[c]` is 1 and `prog_en[c]` is 0, and the entry at `rx_label[8c+7:8c]` is 1, `rx_keep[c]` is 1 for exactly the one cycle after that edge, and `rx_drop[c]` stays 0.
- R7: In the same case with an entry of 0, `rx_drop[c]` is 1 for exactly one cycle, `rx_keep[c]` stays 0, and the pending flag is not set.
- R8: When `rx_eom[c]` is 1 while `prog_en[c]` is 1, neither `rx_keep[c]` nor `rx_drop[c]` pulses, and `rx_pending[c]` is unchanged.
- R9: `rx_pending[c]` rises together with `rx_keep[c]`. It stays 1 until an edge where `pend_clr[c]` is 1 and no new keep occurs; a keep in the same cycle as a clear wins.
- R10: Channels are independent. The table contents, verdicts and pending flags of one channel are unaffected by another channel's inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_en | input | NCH | Per-channel table program enable; also suspends judging |
| hst_sel | input | 1 | Host access strobe |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_addr | input | LBL_W | Label entry addressed by the host |
| hst_wdata | input | NCH | Write data, bit c for channel c |
| hst_rdata | output | 16 | Read data, bit c for channel c, upper byte 0 |
| rx_eom | input | NCH | Per-channel end-of-word strobe |
| rx_label | input | NCH*LBL_W | Labels of the finished words, channel c at bits 8c+7:8c |
| pend_clr | input | NCH | Per-channel pending-flag clear |
| rx_keep | output | NCH | One-cycle accept pulse |
| rx_drop | output | NCH | One-cycle reject pulse |
| rx_pending | output | NCH | Accepted-word pending flag |

## Verification
The bench goes after the gating corners. It writes while only some channels are enabled, so a design that gates writes by the wrong bit, or with an OR over all bits, loads channels that were locked. It sends words while a channel is in programming mode, so a design that keeps judging there emits a keep or a drop it should not. It uses the extreme labels 0x00 and 0xFF, where an off-by-one address decode picks the wrong entry. It clears the pending flag in the same cycle as a new accept, so a design that gives the clear priority loses a word. It also checks the exact cycle of each verdict pulse, so a design with an extra register stage or a pulse held too long is caught.

// File: rtl/lbl_pkg.sv
package lbl_pkg;
    localparam int DEF_NCH   = 8;
    localparam int DEF_LBL_W = 8;
    localparam int RD_W      = 16;

    typedef struct packed {
        logic keep;
        logic drop;
    } verdict_t;

    // Verdict for one finished word: nothing while the table is being programmed.
    function automatic verdict_t judge(input logic eom, input logic locked_for_prog,
                                       input logic entry);
        verdict_t v;
        v.keep = eom & ~locked_for_prog & entry;
        v.drop = eom & ~locked_for_prog & ~entry;
        return v;
    endfunction
endpackage

// File: rtl/lbl_table.sv
module lbl_table #(
    parameter int LBL_W = lbl_pkg::DEF_LBL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [LBL_W-1:0] wr_addr,
    input  logic             wr_bit,
    input  logic [LBL_W-1:0] host_addr,
    output logic             host_bit,
    input  logic [LBL_W-1:0] rx_addr,
    output logic             rx_bit
);
    localparam int DEPTH = 1 << LBL_W;

    logic [DEPTH-1:0] entries;

    always_ff @(posedge clk) begin
        if (rst) begin
            entries <= '0;
        end else if (wr_en) begin
            entries[wr_addr] <= wr_bit;
        end
    end

    assign host_bit = entries[host_addr];
    assign rx_bit   = entries[rx_addr];

    // R3: without a write enable the table content does not move
    assert_locked_table_R3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(entries));
    // R2: the addressed entry takes the written bit
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (entries[$past(wr_addr)] == $past(wr_bit)));
endmodule

// File: rtl/lbl_judge.sv
module lbl_judge (
    input  logic clk,
    input  logic rst,
    input  logic eom,
    input  logic prog_mode,
    input  logic entry,
    input  logic clr,
    output logic keep,
    output logic drop,
    output logic pending
);
    import lbl_pkg::*;

    verdict_t nxt;
    assign nxt = judge(eom, prog_mode, entry);

    always_ff @(posedge clk) begin
        if (rst) begin
            keep    <= 1'b0;
            drop    <= 1'b0;
            pending <= 1'b0;
        end else begin
            keep    <= nxt.keep;
            drop    <= nxt.drop;
            pending <= nxt.keep | (pending & ~clr);
        end
    end

    // R7: a word is never both kept and dropped
    assert_keep_drop_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(keep && drop));
    // R8: a word finished during programming yields no verdict
    assert_silent_in_prog_R8: assert property (@(posedge clk) disable iff (rst)
        (eom && prog_mode) |=> (!keep && !drop));
    // R7: a rejected word never raises the pending flag
    assert_drop_no_pend_R7: assert property (@(posedge clk) disable iff (rst)
        (drop && !$past(pending)) |-> !pending);
    // R9: pending holds while no clear is requested
    assert_pend_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (pending && !clr) |=> pending);
    // R6: a keep pulse lasts one cycle unless another word is accepted
    assert_keep_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        (keep && !eom) |=> !keep);
endmodule

// File: rtl/lbl_host_port.sv
module lbl_host_port #(
    parameter int NCH = lbl_pkg::DEF_NCH
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rd,
    input  logic [NCH-1:0]          bits,
    output logic [lbl_pkg::RD_W-1:0] rdata
);
    localparam int RD_W = lbl_pkg::RD_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd) begin
            rdata <= RD_W'(bits);
        end
    end

    // R4: read data holds between reads
    assert_rdata_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(rdata));
endmodule

// File: rtl/lbl_accept_matrix.sv
module lbl_accept_matrix #(
    parameter int NCH   = lbl_pkg::DEF_NCH,
    parameter int LBL_W = lbl_pkg::DEF_LBL_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NCH-1:0]       prog_en,
    input  logic                 hst_sel,
    input  logic                 hst_wr,
    input  logic [LBL_W-1:0]     hst_addr,
    input  logic [NCH-1:0]       hst_wdata,
    output logic [15:0]          hst_rdata,
    input  logic [NCH-1:0]       rx_eom,
    input  logic [NCH*LBL_W-1:0] rx_label,
    input  logic [NCH-1:0]       pend_clr,
    output logic [NCH-1:0]       rx_keep,
    output logic [NCH-1:0]       rx_drop,
    output logic [NCH-1:0]       rx_pending
);
    logic           host_wr;
    logic           host_rd;
    logic [NCH-1:0] host_bits;
    logic [NCH-1:0] rx_bits;

    assign host_wr = hst_sel & hst_wr;
    assign host_rd = hst_sel & ~hst_wr;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        lbl_table #(.LBL_W(LBL_W)) i_table (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (host_wr & prog_en[c]),
            .wr_addr  (hst_addr),
            .wr_bit   (hst_wdata[c]),
            .host_addr(hst_addr),
            .host_bit (host_bits[c]),
            .rx_addr  (rx_label[c*LBL_W +: LBL_W]),
            .rx_bit   (rx_bits[c])
        );

        lbl_judge i_judge (
            .clk      (clk),
            .rst      (rst),
            .eom      (rx_eom[c]),
            .prog_mode(prog_en[c]),
            .entry    (rx_bits[c]),
            .clr      (pend_clr[c]),
            .keep     (rx_keep[c]),
            .drop     (rx_drop[c]),
            .pending  (rx_pending[c])
        );
    end

    lbl_host_port #(.NCH(NCH)) i_host (
        .clk  (clk),
        .rst  (rst),
        .rd   (host_rd),
        .bits (host_bits),
        .rdata(hst_rdata)
    );
endmodule

// File: tb/test_lbl_accept_matrix.sv
module test_lbl_accept_matrix;
    localparam int NCH = 8;
    localparam int LW  = 8;

    logic               clk = 1'b0;
    logic               rst;
    logic [NCH-1:0]     prog_en;
    logic               hst_sel, hst_wr;
    logic [LW-1:0]      hst_addr;
    logic [NCH-1:0]     hst_wdata;
    logic [15:0]        hst_rdata;
    logic [NCH-1:0]     rx_eom;
    logic [NCH*LW-1:0]  rx_label;
    logic [NCH-1:0]     pend_clr;
    logic [NCH-1:0]     rx_keep, rx_drop, rx_pending;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    lbl_accept_matrix i_lbl_accept_matrix (
        .clk(clk), .rst(rst), .prog_en(prog_en), .hst_sel(hst_sel), .hst_wr(hst_wr),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .rx_eom(rx_eom), .rx_label(rx_label), .pend_clr(pend_clr),
        .rx_keep(rx_keep), .rx_drop(rx_drop), .rx_pending(rx_pending)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        hst_sel = 0; hst_wr = 0; rx_eom = '0; pend_clr = '0;
    endtask

    task automatic hwrite(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        hst_sel = 1; hst_wr = 1; hst_addr = a; hst_wdata = d;
        @(negedge clk);
        idle();
    endtask

    task automatic hread(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        hst_sel = 1; hst_wr = 0; hst_addr = a;
        @(negedge clk);
        idle();
        d = hst_rdata;
    endtask

    // Send one word per masked channel with the same label; sample verdicts.
    task automatic send(input logic [7:0] mask, input logic [7:0] lbl,
                        output logic [7:0] k, output logic [7:0] dr);
        @(negedge clk);
        rx_eom = mask;
        rx_label = {NCH{lbl}};
        @(negedge clk);
        idle();
        k = rx_keep; dr = rx_drop;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        logic [7:0] k, dr;
        check("R1 keep", 32'(rx_keep), 0);
        check("R1 drop", 32'(rx_drop), 0);
        check("R1 pending", 32'(rx_pending), 0);
        check("R1 rdata", 32'(hst_rdata), 0);
        hread(8'h00, d); check("R1 entry 00", 32'(d), 0);
        hread(8'hFF, d); check("R1 entry FF", 32'(d), 0);
        send(8'hFF, 8'h5A, k, dr);
        check("R1 all dropped keep", 32'(k), 0);
        check("R1 all dropped drop", 32'(dr), 32'hFF);
    endtask

    task automatic t_program();
        logic [15:0] d;
        @(negedge clk); prog_en = 8'hFF;
        hwrite(8'h00, 8'hA5);
        hwrite(8'hFF, 8'h3C);
        hwrite(8'h80, 8'hFF);
        hread(8'h00, d); check("R2 entry 00", 32'(d), 32'h00A5);
        hread(8'hFF, d); check("R2 entry FF", 32'(d), 32'h003C);
        hread(8'h80, d); check("R4 upper byte zero", 32'(d[15:8]), 0);
        check("R4 low byte", 32'(d[7:0]), 32'hFF);
        hread(8'h01, d); check("R2 neighbour untouched", 32'(d), 0);
        // rdata holds after read with no further access
        @(negedge clk); @(negedge clk);
        check("R4 rdata holds", 32'(hst_rdata), 0);
    endtask

    task automatic t_locked();
        logic [15:0] d;
        @(negedge clk); prog_en = 8'h0F;
        hwrite(8'h80, 8'h00);
        @(negedge clk); prog_en = 8'h00;
        hread(8'h80, d);
        check("R3 locked channels keep old bits", 32'(d), 32'h00F0);
        hwrite(8'h00, 8'hFF);
        hread(8'h00, d);
        check("R3 write with all locked", 32'(d), 32'h00A5);
        check("R5 read while not programming", 32'(d[7:0]), 32'hA5);
    endtask

    task automatic t_receive();
        logic [7:0] k, dr;
        send(8'hFF, 8'h00, k, dr);
        check("R6 keep label 00", 32'(k), 32'hA5);
        check("R7 drop label 00", 32'(dr), 32'h5A);
        check("R9 pending follows keep", 32'(rx_pending), 32'hA5);
        @(negedge clk);
        check("R6 keep one cycle", 32'(rx_keep), 0);
        check("R7 drop one cycle", 32'(rx_drop), 0);
        send(8'h03, 8'hFF, k, dr);
        check("R10 only ch0/1 keep", 32'(k), 32'h00);
        check("R10 only ch0/1 drop", 32'(dr), 32'h03);
        check("R7 drop leaves pending", 32'(rx_pending), 32'hA5);
    endtask

    task automatic t_prog_mode();
        logic [7:0] k, dr;
        logic [15:0] d;
        @(negedge clk); prog_en = 8'h81;
        send(8'hFF, 8'h00, k, dr);
        check("R8 no keep in prog", 32'(k), 32'h24);
        check("R8 no drop in prog", 32'(dr), 32'h5A);
        check("R8 pending unchanged", 32'(rx_pending), 32'hA5);
        hread(8'hFF, d);
        check("R5 read during prog", 32'(d), 32'h003C);
        @(negedge clk); prog_en = 8'h00;
        send(8'h01, 8'h00, k, dr);
        check("R8 back to receive", 32'(k), 32'h01);
    endtask

    task automatic t_pending();
        @(negedge clk);
        pend_clr = 8'h04;
        @(negedge clk);
        idle();
        check("R9 clear", 32'(rx_pending), 32'hA1);
        @(negedge clk);
        pend_clr = 8'h01; rx_eom = 8'h01; rx_label = '0;
        @(negedge clk);
        idle();
        check("R9 keep beats clear", 32'(rx_pending), 32'hA1);
        @(negedge clk); pend_clr = 8'hFF;
        @(negedge clk); idle();
        check("R9 clear all", 32'(rx_pending), 0);
    endtask

    initial begin
        rst = 1; prog_en = '0; hst_addr = '0; hst_wdata = '0; rx_label = '0;
        idle();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_program();
        t_locked();
        t_receive();
        t_prog_mode();
        t_pending();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule